// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block lets synchronous on-chip logic read and write one byte at a time in an external asynchronous static RAM of 131072 bytes. A requester presents a read or write over a valid/ready handshake, carrying a 17-bit byte address and, for writes, one data byte. Read results come back on a separate byte bus with a one-cycle valid strobe. The controller handles one access at a time. Its ready output is high only while it is idle.

On the memory side the controller drives the address bus and a pair of chip selects. One select is active low and the other active high, and the memory is enabled only when both are asserted. It also drives an active-low output enable, an active-low write enable, and an 8-bit data path split into an outgoing byte, an incoming byte and a tri-state enable for an external pad. Every pin is driven from a register. Access lengths are counted in system clock cycles set by parameters. The defaults suit a 100 MHz clock and a memory with a 10 ns access time: a read lasts two cycles, and the write-enable pulse lasts one cycle.

A write that directly follows a read gets extra turnaround cycles, during which every memory control is inactive. These cover the time the memory may keep driving the data pins after its output enable rises. During a write the controller drives the data bus only in the cycle before write enable falls and while write enable is low. It stops driving in the same cycle that write enable returns high.

Top module: `async_sram_ctrl`

## Requirements
- R1: After a synchronous active-high reset, reqReady is 1, memCsN is 1, memCs is 0, memOeN is 1, memWeN is 1, memDqOe is 0 and rspValid is 0.
- R2: A read accepted at a clock edge (reqValid and reqReady both 1, reqWrite 0) occupies the next RD_CYC cycles. In each of them memAddr equals the request address, memCsN is 0, memCs is 1, memOeN is 0, memWeN is 1 and memDqOe is 0.
- R3: The byte on memDqIn in the last read cycle is presented on rspData, with rspValid 1 for exactly the one following cycle. In every other cycle rspValid is 0.
- R4: A write occupies one setup cycle followed by WE_CYC cycles with memWeN 0. In all of these cycles the memory is selected, memOeN is 1, memDqOe is 1, and memAddr and memDqOut hold the request address and byte. memWeN is 1 in the setup cycle.
- R5: In the cycle in which memWeN returns to 1, memDqOe is 0 and both chip selects are deasserted.
- R6: If the last transaction was a read and a write is accepted next, TURN_CYC cycles with all memory controls inactive and the driver off come before the write's setup cycle.
- R7: reqReady is 1 only when no access is in progress, and then all memory controls are inactive. A request held valid while the block is busy is accepted at the first edge at which reqReady is 1.
- R8: memDqOe is never 1 in a cycle in which memOeN is 0.
- R9: A reset asserted in the middle of a read or a write leaves all memory controls inactive, memDqOe 0, rspValid 0 and reqReady 1 in the cycle after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and accepting a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Byte address |
| reqWdata | input | 8 | Byte to write |
| rspValid | output | 1 | One-cycle strobe for rspData |
| rspData | output | 8 | Byte read from memory |
| memAddr | output | 17 | Memory address bus |
| memCsN | output | 1 | Active-low chip select |
| memCs | output | 1 | Active-high chip select |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memDqOut | output | 8 | Byte for the data pad driver |
| memDqOe | output | 1 | Data pad driver enable |
| memDqIn | input | 8 | Byte received from the data pad |

## Verification
The assertions check, on every cycle, the pin relationships that hold regardless of the request stream. Write enable is low only while the memory is selected and the driver is on. The driver and the output enable are never active together. The driver turns off in the same cycle that write enable rises and stays off in the cycles after output enable rises. Ready is high only with idle pins, and the response strobe lasts a single cycle. Only the bench scenarios can show the exact cycle counts of each access phase, that the right byte comes back from the right address, that the turnaround appears only when a write follows a read, that a request held valid during a busy period is accepted at the right moment, and that the pins return to idle after a reset in mid-access.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_SETUP,
    ST_WPULSE
  } ctl_state_e;

  // Strobes from control to datapath; pin intents apply to the next cycle.
  typedef struct packed {
    logic selNext;
    logic oeNext;
    logic weNext;
    logic driveNext;
    logic loadReq;
    logic capRead;
  } strobe_t;

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int RD_CYC   = 2,
  parameter int WE_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int MAX_AB = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
  localparam int MAX_C  = (MAX_AB > TURN_CYC) ? MAX_AB : TURN_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  ctl_state_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic lastRead, lastReadNext;
  logic cntDone;

  assign cntDone  = (cnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stateNext    = state;
    cntNext      = cnt;
    lastReadNext = lastRead;
    strb.loadReq = 1'b0;
    strb.capRead = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.loadReq = 1'b1;
          if (!reqWrite) begin
            stateNext = ST_READ;
            cntNext   = CNT_W'(RD_CYC - 1);
          end else if (TURN_CYC > 0 && lastRead) begin
            stateNext = ST_TURN;
            cntNext   = CNT_W'(TURN_CYC - 1);
          end else begin
            stateNext = ST_SETUP;
          end
        end
      end
      ST_READ: begin
        if (cntDone) begin
          strb.capRead = 1'b1;
          lastReadNext = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (cntDone) stateNext = ST_SETUP;
        else         cntNext   = cnt - 1'b1;
      end
      ST_SETUP: begin
        lastReadNext = 1'b0;
        stateNext    = ST_WPULSE;
        cntNext      = CNT_W'(WE_CYC - 1);
      end
      ST_WPULSE: begin
        if (cntDone) stateNext = ST_IDLE;
        else         cntNext   = cnt - 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // Pin intents decoded from the next state so that pins come out of registers.
  always_comb begin
    strb.selNext   = (stateNext == ST_READ) || (stateNext == ST_SETUP) ||
                     (stateNext == ST_WPULSE);
    strb.oeNext    = (stateNext == ST_READ);
    strb.weNext    = (stateNext == ST_WPULSE);
    strb.driveNext = (stateNext == ST_SETUP) || (stateNext == ST_WPULSE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastRead <= 1'b0;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      lastRead <= lastReadNext;
    end
  end

  // R6: a turnaround phase is only ever followed by the write setup phase
  assert_turn_leads_setup_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TURN && cntDone) |=> (state == ST_SETUP));

  // R3: capture happens only when leaving the read phase
  assert_cap_in_read_R3: assert property (@(posedge clk) disable iff (rst)
    strb.capRead |-> (state == ST_READ) && (stateNext == ST_IDLE));

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath
  import sramc_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memCs,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;

  always_ff @(posedge clk) begin
    if (strb.loadReq) begin
      addrReg  <= reqAddr;
      wdataReg <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      memCsN   <= 1'b1;
      memCs    <= 1'b0;
      memOeN   <= 1'b1;
      memWeN   <= 1'b1;
      memDqOe  <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      memCsN   <= ~strb.selNext;
      memCs    <= strb.selNext;
      memOeN   <= ~strb.oeNext;
      memWeN   <= ~strb.weNext;
      memDqOe  <= strb.driveNext;
      rspValid <= strb.capRead;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.capRead) rdataReg <= memDqIn;
  end

  assign memAddr  = addrReg;
  assign memDqOut = wdataReg;
  assign rspData  = rdataReg;

  // R4: write enable low only with the part selected, outputs off, driver on
  assert_we_selected_R4: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> (!memCsN && memCs && memOeN && memDqOe));

  // R4: the single driven cycle with write enable high is followed by the pulse
  assert_setup_then_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (memDqOe && memWeN) |=> !memWeN);

  // R5: driver and selects released as write enable rises
  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (!memDqOe && memCsN && !memCs));

  // R8: never drive against the memory's outputs
  assert_no_contention_R8: assert property (@(posedge clk) disable iff (rst)
    memDqOe |-> memOeN);

  // R6: driver stays off in the cycle after a read cycle
  assert_float_gap_R6: assert property (@(posedge clk) disable iff (rst)
    !memOeN |=> !memDqOe);

  generate
    if (TURN_CYC > 0) begin : g_turn_chk
      // R6: with turnaround enabled, two cycles pass before the driver turns on
      assert_float_gap2_R6: assert property (@(posedge clk) disable iff (rst)
        $past(!memOeN, 2) |-> !memDqOe);
    end
  endgenerate

  // R3: the response strobe lasts one cycle
  assert_rsp_single_R3: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int RD_CYC   = 2,
  parameter int WE_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memCs,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t strb;

  sramc_ctrl #(
    .RD_CYC  (RD_CYC),
    .WE_CYC  (WE_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  sramc_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .TURN_CYC(TURN_CYC)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memCsN  (memCsN),
    .memCs   (memCs),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .rspValid(rspValid),
    .rspData (rspData)
  );

  // R7: ready only with all memory controls idle
  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (memCsN && !memCs && memOeN && memWeN && !memDqOe));

  // R9: the cycle after a reset edge shows idle pins
  assert_reset_idle_R9: assert property (@(posedge clk)
    $past(rst) |-> (memCsN && !memCs && memOeN && memWeN && !memDqOe && !rspValid));

endmodule

// File: tb/async_sram_ctrl_bench.sv
`timescale 1ns/1ps
module async_sram_ctrl_bench;

  localparam int ADDR_W   = 17;
  localparam int DATA_W   = 8;
  localparam int RD_CYC   = 2;
  localparam int WE_CYC   = 1;
  localparam int TURN_CYC = 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              reqReady;
  logic              rspValid;
  logic [DATA_W-1:0] rspData;
  logic [ADDR_W-1:0] memAddr;
  logic              memCsN, memCs, memOeN, memWeN, memDqOe;
  logic [DATA_W-1:0] memDqOut;
  logic [DATA_W-1:0] memDqIn = 8'h3C;

  async_sram_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC),
    .WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC)
  ) u_async_sram_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memCsN(memCsN), .memCs(memCs), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    bit          ready;
    bit          sel;
    bit          oe;
    bit          we;
    bit          drv;
    bit          chkA;
    logic [16:0] a;
    logic [7:0]  d;
    bit          rv;
    logic [7:0]  rd;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [7:0]  memModel[int];
  logic [7:0]  refMem[int];
  int          checks = 0;
  int          failures = 0;
  bit          lastRead = 0;
  string       idleTag = "R1";
  bit          done = 0;

  function automatic void chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endfunction

  function automatic logic [7:0] refRead(int a);
    return refMem.exists(a) ? refMem[a] : 8'hFF;
  endfunction

  function automatic exp_t mk(bit ready, bit sel, bit oe, bit we, bit drv,
                              logic [16:0] a, logic [7:0] d, string tag);
    exp_t e;
    e.ready = ready; e.sel = sel; e.oe = oe; e.we = we; e.drv = drv;
    e.chkA = sel; e.a = a; e.d = d; e.rv = 0; e.rd = '0; e.tag = tag;
    return e;
  endfunction

  task automatic tick(input bit v, input bit w, input logic [16:0] a,
                      input logic [7:0] d, input bit rstIn, output bit acc);
    exp_t e;
    @(negedge clk);
    // external memory model
    if (!memCsN && memCs && !memWeN) memModel[int'(memAddr)] = memDqOut;
    if (!memCsN && memCs && !memOeN && memWeN)
      memDqIn = memModel.exists(int'(memAddr)) ? memModel[int'(memAddr)] : 8'hFF;
    else
      memDqIn = 8'h3C;
    // reference comparison for this cycle
    if (expQ.size() > 0) e = expQ.pop_front();
    else                 e = mk(1, 0, 0, 0, 0, '0, '0, idleTag);
    chk(reqReady == e.ready, e.tag, "reqReady", reqReady, e.ready);
    chk(memCsN == !e.sel && memCs == e.sel, e.tag, "selects", {memCsN, memCs}, {!e.sel, e.sel});
    chk(memOeN == !e.oe, e.tag, "memOeN", memOeN, !e.oe);
    chk(memWeN == !e.we, e.tag, "memWeN", memWeN, !e.we);
    chk(memDqOe == e.drv, e.tag, "memDqOe", memDqOe, e.drv);
    if (e.chkA) chk(memAddr == e.a, e.tag, "memAddr", memAddr, e.a);
    if (e.drv)  chk(memDqOut == e.d, e.tag, "memDqOut", memDqOut, e.d);
    chk(rspValid == e.rv, e.tag, "rspValid", rspValid, e.rv);
    if (e.rv) chk(rspData == e.rd, e.tag, "rspData", rspData, e.rd);
    chk(!(memDqOe && !memOeN), "R8", "contention", {memDqOe, memOeN}, 2'b01);
    // drive the next request
    acc = v && e.ready && !rstIn;
    reqValid = v; reqWrite = w; reqAddr = a; reqWdata = d;
    rst = rstIn;
    if (rstIn) begin
      reqValid = 0;
      expQ.delete();
      lastRead = 0;
      expQ.push_back(mk(1, 0, 0, 0, 0, '0, '0, "R9"));
    end else if (acc) begin
      if (!w) begin
        for (int i = 0; i < RD_CYC; i++) expQ.push_back(mk(0, 1, 1, 0, 0, a, d, "R2"));
        e = mk(1, 0, 0, 0, 0, '0, '0, "R3");
        e.rv = 1; e.rd = refRead(int'(a));
        expQ.push_back(e);
        lastRead = 1;
      end else begin
        if (lastRead)
          for (int i = 0; i < TURN_CYC; i++) expQ.push_back(mk(0, 0, 0, 0, 0, '0, '0, "R6"));
        expQ.push_back(mk(0, 1, 0, 0, 1, a, d, "R4"));
        for (int i = 0; i < WE_CYC; i++) expQ.push_back(mk(0, 1, 0, 1, 1, a, d, "R4"));
        expQ.push_back(mk(1, 0, 0, 0, 0, '0, '0, "R5"));
        refMem[int'(a)] = d;
        lastRead = 0;
      end
    end
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) tick(0, 0, '0, '0, 0, acc);
  endtask

  task automatic issue(input bit w, input logic [16:0] a, input logic [7:0] d);
    bit acc;
    acc = 0;
    while (!acc) tick(1, w, a, d, 0, acc);
  endtask

  task automatic doReset();
    bit acc;
    tick(0, 0, '0, '0, 1, acc);
    tick(0, 0, '0, '0, 0, acc);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lfsr;
    bit acc;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset state
    idle(3);
    idleTag = "R7";
    // R4 R5: writes at both ends of the address range
    issue(1, 17'h00000, 8'h5A);
    issue(1, 17'h1FFFF, 8'hC3);
    idle(2);
    // R2 R3: reads back; second held valid during the first (R7)
    issue(0, 17'h00000, 8'h00);
    issue(0, 17'h1FFFF, 8'h00);
    // R6: write right after a read gets the turnaround
    issue(1, 17'h00010, 8'h81);
    issue(0, 17'h00010, 8'h00);
    // unwritten location
    issue(0, 17'h0ABCD, 8'h00);
    idle(3);
    // R9: reset in the middle of a read and of a write
    tick(1, 0, 17'h00000, 8'h00, 0, acc);
    tick(0, 0, '0, '0, 0, acc);
    doReset();
    issue(1, 17'h12345, 8'h77);
    doReset();
    idle(2);
    // mixed traffic
    lfsr = 32'h1ACE;
    for (int i = 0; i < 300; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h8000_0057 : 0);
      issue(lfsr[4], {lfsr[9] ? 13'h1FFF : 13'h0000, lfsr[3:0]}, lfsr[19:12]);
      if (lfsr[7]) idle(lfsr[6:5]);
    end
    idle(6);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule